// File: doc/BRIEF.md
# Whole-Packet Receive Buffer

This block sits at the head of a network receive path. It takes 64-bit flits from the link, each flit tagged with an end-of-packet marker, and hands them to the downstream memory writer as a valid/ready stream. The link side has no ready signal. The block takes every flit offered, so it has to decide by itself what to keep.

Each arriving packet is written under a provisional write position. The packet becomes visible to the reader only when its final flit has been stored. If the storage fills up while a packet is still arriving, the provisional position snaps back to the last committed packet boundary. The block then discards every flit of that packet up to and including its final flit. As a result the reader only ever sees complete packets, in arrival order. A count of stored committed flits is exported so a flow-control stage can watch how full the buffer is. The capacity `DEPTH` is a parameter in flits and must be a power of two.

Top module: `pkt_drop_rxbuf`

## Requirements
- R1: After reset `out_valid_o` is low and `occupancy_o` is 0.
- R2: A stored packet is delivered with its flits in arrival order. `out_last_o` is high on its final flit only, and `out_valid_o` is high in the cycle after its final input flit is taken.
- R3: While a packet is still arriving, none of its flits is visible: `out_valid_o` stays low and `occupancy_o` does not change until its final flit is taken.
- R4: `occupancy_o` rises by the packet length when a packet commits and falls by one for each output handshake (`out_valid_o` and `out_ready_i` both high). It never exceeds `DEPTH`.
- R5: A packet whose flits do not all fit in the free space is discarded completely. Packets that were already committed are delivered unchanged.
- R6: Once a packet starts being discarded, its remaining flits up to and including the flit with `in_last_i` high are discarded, even if space is freed in the meantime.
- R7: A packet longer than `DEPTH` flits is always discarded, and the next packet is stored normally.
- R8: While `out_valid_o` is high and `out_ready_i` is low, `out_valid_o`, `out_data_o` and `out_last_o` hold their values.
- R9: A packet that exactly fills the free space is stored, and `occupancy_o` then equals `DEPTH`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input flit present; always taken |
| in_data_i | input | 64 | Input flit data |
| in_last_i | input | 1 | Input flit ends its packet |
| out_valid_o | output | 1 | Output flit available |
| out_ready_i | input | 1 | Downstream accepts the output flit |
| out_data_o | output | 64 | Output flit data |
| out_last_o | output | 1 | Output flit ends its packet |
| occupancy_o | output | $clog2(DEPTH+1) | Committed flits currently stored |

## Verification
The hardest case to reach is a packet that overflows partway through, followed by space opening up before that packet has ended. Only this case shows whether the discard state lasts to the end-of-packet flit. The stimulus fills most of the buffer with one committed packet and then starts a second packet until it overflows. With the input idle, it drains the buffer completely and then sends the tail of the second packet into an empty buffer. Occupancy and output valid must stay at zero, and a clean packet must follow.

// File: rtl/rxbuf_pkg.sv
package rxbuf_pkg;
  localparam int FLIT_W = 64;

  typedef struct packed {
    logic              last;
    logic [FLIT_W-1:0] data;
  } flit_t;
endpackage

// File: rtl/rxbuf_store.sv
module rxbuf_store
  import rxbuf_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  flit_t         wflit_i,
  input  logic [AW-1:0] raddr_i,
  output flit_t         rflit_o
);
  flit_t mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wflit_i;
  end

  assign rflit_o = mem_q[raddr_i];
endmodule

// File: rtl/rxbuf_ingress.sv
module rxbuf_ingress #(
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH),
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          in_valid_i,
  input  logic          in_last_i,
  input  logic [CW-1:0] occ_i,
  output logic          we_o,
  output logic [AW-1:0] waddr_o,
  output logic          commit_o,
  output logic [CW-1:0] commit_len_o
);
  logic [AW-1:0] tail_q, tent_q;
  logic [CW-1:0] tent_cnt_q;
  logic          drop_q;
  logic [CW:0]   used;
  logic          room, accept;

  // committed + provisional flits; space check is conservative vs same-cycle pops
  assign used   = {1'b0, occ_i} + {1'b0, tent_cnt_q};
  assign room   = used < (CW+1)'(DEPTH);
  assign accept = in_valid_i && !drop_q && room;

  assign we_o         = accept;
  assign waddr_o      = tent_q;
  assign commit_o     = accept && in_last_i;
  assign commit_len_o = tent_cnt_q + CW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tail_q     <= '0;
      tent_q     <= '0;
      tent_cnt_q <= '0;
      drop_q     <= 1'b0;
    end else if (in_valid_i) begin
      if (drop_q) begin
        if (in_last_i) drop_q <= 1'b0;
      end else if (room) begin
        tent_q <= tent_q + AW'(1);
        if (in_last_i) begin
          tail_q     <= tent_q + AW'(1);
          tent_cnt_q <= '0;
        end else begin
          tent_cnt_q <= tent_cnt_q + CW'(1);
        end
      end else begin
        // overflow: roll back to last packet boundary
        tent_q     <= tail_q;
        tent_cnt_q <= '0;
        drop_q     <= !in_last_i;
      end
    end
  end

  p_room_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ({1'b0, occ_i} + {1'b0, tent_cnt_q}) <= (CW+1)'(DEPTH));

  p_rollback_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(drop_q) |-> (tent_cnt_q == '0 && tent_q == tail_q));

  p_drop_until_last_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drop_q && !(in_valid_i && in_last_i)) |=> drop_q);
endmodule

// File: rtl/rxbuf_egress.sv
module rxbuf_egress #(
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH),
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          commit_i,
  input  logic [CW-1:0] commit_len_i,
  input  logic          out_ready_i,
  output logic          out_valid_o,
  output logic [AW-1:0] raddr_o,
  output logic [CW-1:0] occ_o
);
  logic [AW-1:0] head_q;
  logic [CW-1:0] occ_q;
  logic          pop;

  // only committed flits are counted, so any nonzero count is whole packets
  assign out_valid_o = occ_q != '0;
  assign pop         = out_valid_o && out_ready_i;
  assign raddr_o     = head_q;
  assign occ_o       = occ_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      occ_q  <= '0;
    end else begin
      if (pop) head_q <= head_q + AW'(1);
      occ_q <= occ_q + (commit_i ? commit_len_i : '0) - (pop ? CW'(1) : '0);
    end
  end

  p_occ_max_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    occ_q <= CW'(DEPTH));

  p_pop_dec_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop && !commit_i) |=> occ_q == $past(occ_q) - CW'(1));
endmodule

// File: rtl/pkt_drop_rxbuf.sv
module pkt_drop_rxbuf
  import rxbuf_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic [FLIT_W-1:0] in_data_i,
  input  logic              in_last_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [FLIT_W-1:0] out_data_o,
  output logic              out_last_o,
  output logic [CW-1:0]     occupancy_o
);
  logic          we, commit;
  logic [AW-1:0] waddr, raddr;
  logic [CW-1:0] commit_len, occ;
  flit_t         wflit, rflit;

  assign wflit = '{last: in_last_i, data: in_data_i};

  rxbuf_ingress #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_ingress (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .in_valid_i   (in_valid_i),
    .in_last_i    (in_last_i),
    .occ_i        (occ),
    .we_o         (we),
    .waddr_o      (waddr),
    .commit_o     (commit),
    .commit_len_o (commit_len)
  );

  rxbuf_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
    .clk_i   (clk_i),
    .we_i    (we),
    .waddr_i (waddr),
    .wflit_i (wflit),
    .raddr_i (raddr),
    .rflit_o (rflit)
  );

  rxbuf_egress #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_egress (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .commit_i     (commit),
    .commit_len_i (commit_len),
    .out_ready_i  (out_ready_i),
    .out_valid_o  (out_valid_o),
    .raddr_o      (raddr),
    .occ_o        (occ)
  );

  assign out_data_o  = rflit.data;
  assign out_last_o  = rflit.last;
  assign occupancy_o = occ;

  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o) && $stable(out_last_o)));
endmodule

// File: tb/tb_pkt_drop_rxbuf.sv
module tb_pkt_drop_rxbuf;
  localparam int DEPTH = 16;
  localparam int CW    = $clog2(DEPTH + 1);

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          in_valid = 1'b0;
  logic [63:0]   in_data = '0;
  logic          in_last = 1'b0;
  logic          out_valid;
  logic          out_ready = 1'b0;
  logic [63:0]   out_data;
  logic          out_last;
  logic [CW-1:0] occ;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  pkt_drop_rxbuf #(.DEPTH(DEPTH)) dut (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .in_valid_i  (in_valid),
    .in_data_i   (in_data),
    .in_last_i   (in_last),
    .out_valid_o (out_valid),
    .out_ready_i (out_ready),
    .out_data_o  (out_data),
    .out_last_o  (out_last),
    .occupancy_o (occ)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] flit(int id, int idx);
    return {id[31:0], idx[31:0]};
  endfunction

  task automatic send_flits(int id, int first, int n, bit end_pkt);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = flit(id, first + i);
      in_last  = end_pkt && (i == n - 1);
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_last  = 1'b0;
  endtask

  task automatic drain_chk(string req, int id, int len, int occ_start);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      out_ready = 1'b1;
      chk({req, " valid"}, 64'(out_valid), 64'd1);
      chk({req, " data"}, out_data, flit(id, i));
      chk({req, " last"}, 64'(out_last), 64'(i == len - 1));
      chk("R4 occ during drain", 64'(occ), 64'(occ_start - i));
    end
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 valid", 64'(out_valid), 64'd0);
    chk("R1 occ", 64'(occ), 64'd0);
  endtask

  task automatic t_basic;
    send_flits(1, 0, 3, 1'b1);
    chk("R2 valid after last", 64'(out_valid), 64'd1);
    chk("R4 occ after commit", 64'(occ), 64'd3);
    drain_chk("R2", 1, 3, 3);
    chk("R4 occ empty", 64'(occ), 64'd0);
    chk("R2 valid empty", 64'(out_valid), 64'd0);
  endtask

  task automatic t_partial;
    send_flits(2, 0, 2, 1'b0);
    chk("R3 valid mid packet", 64'(out_valid), 64'd0);
    chk("R3 occ mid packet", 64'(occ), 64'd0);
    send_flits(2, 2, 1, 1'b1);
    chk("R3 occ after last", 64'(occ), 64'd3);
    drain_chk("R3", 2, 3, 3);
  endtask

  task automatic t_backpressure;
    send_flits(5, 0, 2, 1'b1);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R8 valid held", 64'(out_valid), 64'd1);
      chk("R8 data held", out_data, flit(5, 0));
      chk("R8 last held", 64'(out_last), 64'd0);
    end
    drain_chk("R8", 5, 2, 2);
  endtask

  task automatic t_exact_fill;
    send_flits(6, 0, DEPTH, 1'b1);
    chk("R9 occ full", 64'(occ), 64'(DEPTH));
    send_flits(7, 0, 1, 1'b1);
    chk("R5 occ after drop when full", 64'(occ), 64'(DEPTH));
    drain_chk("R9", 6, DEPTH, DEPTH);
    chk("R5 nothing after full drain", 64'(out_valid), 64'd0);
  endtask

  task automatic t_drop;
    send_flits(8, 0, 10, 1'b1);
    send_flits(9, 0, 8, 1'b1);
    chk("R5 occ unchanged", 64'(occ), 64'd10);
    drain_chk("R5", 8, 10, 10);
    chk("R5 dropped packet absent", 64'(out_valid), 64'd0);
  endtask

  task automatic t_drop_persist;
    send_flits(10, 0, 12, 1'b1);
    send_flits(11, 0, 5, 1'b0);
    chk("R6 occ after overflow", 64'(occ), 64'd12);
    drain_chk("R6 committed", 10, 12, 12);
    send_flits(11, 5, 3, 1'b1);
    chk("R6 tail discarded occ", 64'(occ), 64'd0);
    chk("R6 tail discarded valid", 64'(out_valid), 64'd0);
    send_flits(12, 0, 2, 1'b1);
    chk("R6 next packet occ", 64'(occ), 64'd2);
    drain_chk("R6 next", 12, 2, 2);
  endtask

  task automatic t_oversize;
    send_flits(13, 0, DEPTH + 4, 1'b1);
    chk("R7 oversize occ", 64'(occ), 64'd0);
    chk("R7 oversize valid", 64'(out_valid), 64'd0);
    send_flits(14, 0, 4, 1'b1);
    chk("R7 recover occ", 64'(occ), 64'd4);
    drain_chk("R7", 14, 4, 4);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_partial();
    t_backpressure();
    t_exact_fill();
    t_drop();
    t_drop_persist();
    t_oversize();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule